// File: doc/BRIEF.md
# Routed Interrupt Aggregator

This block gathers 32 external interrupt request lines and presents them to a processor on 4 interrupt outputs. Every request line is synchronized, then detected either as a level or as a transition, with a per-line polarity choice. The result is a latched pending flag per line. Software reads the pending flags back and clears them through a small 16-bit register port.

The 32 lines are handled as two banks of 16. Line `n` lives in bank `n>>4` at bit `n & 15` of that bank's registers. Each output has its own 16-bit enable mask per bank, so any subset of the lines can drive any output. A line may drive several outputs at once. Masking a line never discards its pending flag: the flag stays visible in the status register and drives an output once that output enables it.

Register reads are combinational from the address. Writes take effect at the clock edge on which `regWrEn` is high.

Top module: `irq_router`

## Requirements
- R1: After reset all outputs are 0, and every pending flag, edge select, polarity and enable bit reads back as 0. This means every line starts level-sensitive and active-high.
- R2: A line in level mode (edge bit 0) has a pending flag equal to its active level. An input change is reflected in status and outputs after the third rising clock edge: two edges for synchronization and one for the pending flag. A clear write to a level line whose level is still active leaves its flag set.
- R3: A polarity bit of 1 makes the line active-low. A low input then sets the pending flag.
- R4: A line in edge mode (edge bit 1) sets its pending flag on an inactive-to-active transition of its synchronized input. The flag stays set after the input returns inactive, until a clear write with a 1 in that line's bit.
- R5: A clear write affects only the bits written as 1. Pending flags at 0 bits of the same write are unchanged.
- R6: If a clear write and a new edge event on the same line land on the same clock edge, the pending flag stays set.
- R7: Output `k` is 1 exactly when some line has both its pending flag and its enable bit for output `k` set, taken across both banks.
- R8: A pending line that is disabled on every output still reads as pending in status. Its output rises on the clock edge that writes its enable bit, provided the flag was not cleared first.
- R9: Byte addresses are as follows. Bank `b` has status at `0x40*b`, clear at `0x10+0x40*b`, edge select at `0x20+0x40*b` and polarity at `0x30+0x40*b`. The enable mask for bank `b` and output `k` is at `0x100+0x10*b+0x20*k`. Edge, polarity and enable registers read back the last written value. The clear address and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Asynchronous interrupt request lines |
| regAddr | input | 9 | Register byte address |
| regWrEn | input | 1 | Write strobe, sampled at the rising edge |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| irqOut | output | 4 | Processor interrupt outputs |

## Verification
A corrupted pending flag shows up on the outputs the same cycle, for every output that enables the line. It also shows in the bank status word on the very next read, even when the line is masked. A wrong edge or polarity register changes when flags set or drop, three edges after an input transition. The bench therefore compares outputs against a reference model on every cycle, and status on random reads. Cases where clear and detection coincide are covered by directed cycle-exact steps.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int GROUP_W    = 16;
  parameter int NUM_GROUPS = 2;
  parameter int NUM_OUTS   = 4;
  parameter int ADDR_W     = 9;

  localparam int NUM_SRC   = GROUP_W * NUM_GROUPS;
  localparam int GRP_IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int OUT_IDX_W = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1;

  // address layout (byte offsets)
  localparam int KIND_STRIDE   = 'h10;
  localparam int GROUP_STRIDE  = 'h40;
  localparam int EN_BASE       = 'h100;
  localparam int EN_GRP_STRIDE = 'h10;
  localparam int EN_OUT_STRIDE = 'h20;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_CLEAR, RD_EDGE, RD_POL, RD_ENABLE
  } rdKind_t;

  typedef struct packed {
    logic [NUM_GROUPS-1:0]          clrWr;
    logic [NUM_GROUPS-1:0]          edgeWr;
    logic [NUM_GROUPS-1:0]          polWr;
    logic [NUM_OUTS*NUM_GROUPS-1:0] enWr;   // index out*NUM_GROUPS+group
    rdKind_t                        rdKind;
    logic [GRP_IDX_W-1:0]           rdGroup;
    logic [OUT_IDX_W-1:0]           rdOut;
  } busStrobe_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output busStrobe_t        strb
);
  always_comb begin
    strb        = '0;
    strb.rdKind = RD_NONE;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (regAddr == ADDR_W'(g*GROUP_STRIDE)) begin
        strb.rdKind  = RD_STATUS;
        strb.rdGroup = GRP_IDX_W'(g);
      end
      if (regAddr == ADDR_W'(KIND_STRIDE + g*GROUP_STRIDE)) begin
        strb.rdKind   = RD_CLEAR;
        strb.clrWr[g] = regWrEn;
      end
      if (regAddr == ADDR_W'(2*KIND_STRIDE + g*GROUP_STRIDE)) begin
        strb.rdKind    = RD_EDGE;
        strb.rdGroup   = GRP_IDX_W'(g);
        strb.edgeWr[g] = regWrEn;
      end
      if (regAddr == ADDR_W'(3*KIND_STRIDE + g*GROUP_STRIDE)) begin
        strb.rdKind   = RD_POL;
        strb.rdGroup  = GRP_IDX_W'(g);
        strb.polWr[g] = regWrEn;
      end
    end
    for (int n = 0; n < NUM_OUTS; n++) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (regAddr == ADDR_W'(EN_BASE + g*EN_GRP_STRIDE + n*EN_OUT_STRIDE)) begin
          strb.rdKind                 = RD_ENABLE;
          strb.rdGroup                = GRP_IDX_W'(g);
          strb.rdOut                  = OUT_IDX_W'(n);
          strb.enWr[n*NUM_GROUPS + g] = regWrEn;
        end
      end
    end
  end
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SRC-1:0]                irqIn,
  input  logic [GROUP_W-1:0]                wrData,
  input  busStrobe_t                        strb,
  output logic [GROUP_W-1:0]                rdData,
  output logic [NUM_OUTS-1:0]               irqOut,
  output logic [NUM_SRC-1:0]                pendAll,
  output logic [NUM_SRC-1:0]                edgeAll,
  output logic [NUM_OUTS-1:0][NUM_SRC-1:0]  enAll
);
  logic [NUM_SRC-1:0] sync1, sync2, sync3;
  logic [NUM_SRC-1:0] polAll, clrMask;
  logic [NUM_SRC-1:0] activeNow, activePrev, hit, pendNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= irqIn;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    always_ff @(posedge clk) begin
      if (!rstN) begin
        edgeAll[g*GROUP_W +: GROUP_W] <= '0;
        polAll[g*GROUP_W +: GROUP_W]  <= '0;
      end else begin
        if (strb.edgeWr[g]) edgeAll[g*GROUP_W +: GROUP_W] <= wrData;
        if (strb.polWr[g])  polAll[g*GROUP_W +: GROUP_W]  <= wrData;
      end
    end
    assign clrMask[g*GROUP_W +: GROUP_W] = strb.clrWr[g] ? wrData : '0;

    for (genvar n = 0; n < NUM_OUTS; n++) begin : gOut
      always_ff @(posedge clk) begin
        if (!rstN)
          enAll[n][g*GROUP_W +: GROUP_W] <= '0;
        else if (strb.enWr[n*NUM_GROUPS + g])
          enAll[n][g*GROUP_W +: GROUP_W] <= wrData;
      end
    end
  end

  // detection: a fresh event outranks a clear on the same edge
  assign activeNow  = sync2 ^ polAll;
  assign activePrev = sync3 ^ polAll;
  assign hit        = activeNow & ~activePrev;
  assign pendNext   = (edgeAll & (hit | (pendAll & ~clrMask))) | (~edgeAll & activeNow);

  always_ff @(posedge clk) begin
    if (!rstN) pendAll <= '0;
    else       pendAll <= pendNext;
  end

  always_comb begin
    for (int n = 0; n < NUM_OUTS; n++) irqOut[n] = |(pendAll & enAll[n]);
  end

  always_comb begin
    case (strb.rdKind)
      RD_STATUS: rdData = pendAll[strb.rdGroup*GROUP_W +: GROUP_W];
      RD_EDGE:   rdData = edgeAll[strb.rdGroup*GROUP_W +: GROUP_W];
      RD_POL:    rdData = polAll[strb.rdGroup*GROUP_W +: GROUP_W];
      RD_ENABLE: rdData = enAll[strb.rdOut][strb.rdGroup*GROUP_W +: GROUP_W];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   irqIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [GROUP_W-1:0]   regWrData,
  output logic [GROUP_W-1:0]   regRdData,
  output logic [NUM_OUTS-1:0]  irqOut
);
  busStrobe_t                       strb;
  logic [NUM_SRC-1:0]               pendAll;
  logic [NUM_SRC-1:0]               edgeAll;
  logic [NUM_OUTS-1:0][NUM_SRC-1:0] enAll;

  irq_route_ctrl uCtrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  irq_route_dp uDp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .wrData  (regWrData),
    .strb    (strb),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .pendAll (pendAll),
    .edgeAll (edgeAll),
    .enAll   (enAll)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_route_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic [ADDR_W-1:0]                 regAddr,
  input logic                              regWrEn,
  input logic [GROUP_W-1:0]                regWrData,
  input logic [GROUP_W-1:0]                regRdData,
  input logic [NUM_OUTS-1:0]               irqOut,
  input logic [NUM_SRC-1:0]                pendAll,
  input logic [NUM_SRC-1:0]                edgeAll,
  input logic [NUM_OUTS-1:0][NUM_SRC-1:0]  enAll
);
  logic [NUM_SRC-1:0] clrReq;
  logic               atClrAddr;

  always_comb begin
    clrReq    = '0;
    atClrAddr = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (regAddr == ADDR_W'(KIND_STRIDE + g*GROUP_STRIDE)) begin
        atClrAddr = 1'b1;
        if (regWrEn) clrReq[g*GROUP_W +: GROUP_W] = regWrData;
      end
    end
  end

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pendAll & edgeAll & ~clrReq) & edgeAll & ~pendAll) == '0));

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendAll == '0) |-> (irqOut == '0));

  // R7
  masked_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enAll == '0) |-> (irqOut == '0));

  // R9
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    atClrAddr |-> (regRdData == '0));
endmodule

bind irq_router irq_router_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .pendAll   (pendAll),
  .edgeAll   (edgeAll),
  .enAll     (enAll)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic [8:0]  regAddr = 9'h008;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [3:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_router dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8:0] statusA(int g); return 9'(g*64); endfunction
  function automatic logic [8:0] clrA(int g);    return 9'(16 + g*64); endfunction
  function automatic logic [8:0] edgeA(int g);   return 9'(32 + g*64); endfunction
  function automatic logic [8:0] polA(int g);    return 9'(48 + g*64); endfunction
  function automatic logic [8:0] enA(int g, int n); return 9'(256 + g*16 + n*32); endfunction

  // reference model built from the requirements
  logic [31:0] m1, m2, m3, mPend, mEdge, mPol, mClr;
  logic [31:0] mEn [4];

  always_comb begin
    mClr = '0;
    if (regWrEn)
      for (int g = 0; g < 2; g++)
        if (regAddr == clrA(g)) mClr[g*16 +: 16] = regWrData;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      m1 <= '0; m2 <= '0; m3 <= '0; mPend <= '0; mEdge <= '0; mPol <= '0;
      for (int n = 0; n < 4; n++) mEn[n] <= '0;
    end else begin
      m1 <= irqIn; m2 <= m1; m3 <= m2;
      for (int i = 0; i < 32; i++) begin
        if (mEdge[i])
          mPend[i] <= ((m2[i] ^ mPol[i]) & ~(m3[i] ^ mPol[i])) | (mPend[i] & ~mClr[i]);
        else
          mPend[i] <= m2[i] ^ mPol[i];
      end
      if (regWrEn)
        for (int g = 0; g < 2; g++) begin
          if (regAddr == edgeA(g)) mEdge[g*16 +: 16] <= regWrData;
          if (regAddr == polA(g))  mPol[g*16 +: 16]  <= regWrData;
          for (int n = 0; n < 4; n++)
            if (regAddr == enA(g, n)) mEn[n][g*16 +: 16] <= regWrData;
        end
    end
  end

  function automatic logic [3:0] expOut();
    logic [3:0] r;
    for (int n = 0; n < 4; n++) r[n] = |(mPend & mEn[n]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic regWrite(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 9'h008;
  endtask

  task automatic regRead(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = 9'h008;
  endtask

  task automatic readCheck(input logic [8:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    regRead(a, d);
    check(d == exp, req, 32'(d), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(irqOut == 4'h0, "R1 outputs", 32'(irqOut), 0);
    readCheck(statusA(0), 16'h0, "R1 status0");
    readCheck(statusA(1), 16'h0, "R1 status1");
    readCheck(edgeA(0), 16'h0, "R1 edge0");
    readCheck(polA(1), 16'h0, "R1 pol1");
    readCheck(enA(1, 3), 16'h0, "R1 enable");

    // R2 level latency and clear ineffective
    regWrite(enA(0, 0), 16'h0008);
    @(negedge clk); irqIn[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    check(irqOut[0] == 1'b0, "R2 before latency", 32'(irqOut), 0);
    @(negedge clk);
    check(irqOut[0] == 1'b1, "R2 after latency", 32'(irqOut), 1);
    regWrite(clrA(0), 16'h0008);
    check(irqOut[0] == 1'b1, "R2 clear on active level", 32'(irqOut), 1);
    irqIn[3] = 1'b0;
    repeat (3) @(negedge clk);
    check(irqOut == 4'h0, "R2 level drop", 32'(irqOut), 0);

    // R3 polarity
    regWrite(polA(0), 16'h0020);
    readCheck(statusA(0), 16'h0020, "R3 active-low");
    regWrite(polA(0), 16'h0000);
    readCheck(statusA(0), 16'h0000, "R3 restore");

    // R4 / R8 edge on line 20 (bank 1 bit 4)
    regWrite(edgeA(1), 16'h0010);
    @(negedge clk); irqIn[20] = 1'b1;
    @(negedge clk); irqIn[20] = 1'b0;
    repeat (3) @(negedge clk);
    readCheck(statusA(1), 16'h0010, "R4 held after drop");
    check(irqOut == 4'h0, "R8 masked output", 32'(irqOut), 0);
    regWrite(enA(1, 2), 16'h0010);
    check(irqOut == 4'b0100, "R8 enable delivers", 32'(irqOut), 32'h4);
    regWrite(clrA(1), 16'h0010);
    check(irqOut == 4'h0, "R4 clear", 32'(irqOut), 0);

    // R5 selective clear
    regWrite(edgeA(1), 16'h0030);
    regWrite(enA(1, 2), 16'h0030);
    @(negedge clk); irqIn[21:20] = 2'b11;
    @(negedge clk); irqIn[21:20] = 2'b00;
    repeat (3) @(negedge clk);
    readCheck(statusA(1), 16'h0030, "R5 both pending");
    regWrite(clrA(1), 16'h0020);
    readCheck(statusA(1), 16'h0010, "R5 only written bit cleared");
    regWrite(clrA(1), 16'h0010);

    // R6 clear and new event on the same edge
    @(negedge clk); irqIn[20] = 1'b1;
    @(negedge clk); irqIn[20] = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk); irqIn[20] = 1'b1;
    @(posedge clk); @(posedge clk);
    regWrite(clrA(1), 16'h0010);
    readCheck(statusA(1), 16'h0010, "R6 event beats clear");
    regWrite(clrA(1), 16'h0010);
    readCheck(statusA(1), 16'h0000, "R6 later clear works");
    irqIn[20] = 1'b0;

    // R7 both banks onto one output
    regWrite(enA(0, 1), 16'h0008);
    regWrite(enA(1, 1), 16'h0010);
    @(negedge clk); irqIn[3] = 1'b1;
    repeat (4) @(negedge clk);
    check(irqOut == 4'b0011, "R7 bank0 route", 32'(irqOut), 32'h3);
    irqIn[3] = 1'b0;
    repeat (4) @(negedge clk);
    check(irqOut == 4'b0000, "R7 bank0 dropped", 32'(irqOut), 0);
    irqIn[20] = 1'b1;
    @(negedge clk); irqIn[20] = 1'b0;
    repeat (4) @(negedge clk);
    check(irqOut == 4'b0110, "R7 bank1 route", 32'(irqOut), 32'h6);
    regWrite(clrA(1), 16'h0010);

    // R9 readback and decode
    readCheck(edgeA(1), 16'h0030, "R9 edge readback");
    readCheck(enA(1, 1), 16'h0010, "R9 enable readback");
    readCheck(clrA(0), 16'h0000, "R9 clear reads zero");
    readCheck(9'h008, 16'h0000, "R9 unmapped reads zero");

    // random phase checked against the model (R2 R3 R4 R5 R7)
    for (int it = 0; it < 3000; it++) begin
      int op;
      int g;
      @(negedge clk);
      check(irqOut == expOut(), "R7 random output", 32'(irqOut), 32'(expOut()));
      irqIn = irqIn ^ ($urandom & $urandom & $urandom);
      op = $urandom_range(0, 19);
      g  = $urandom_range(0, 1);
      case (op)
        0: regWrite(edgeA(g), 16'($urandom));
        1: regWrite(polA(g), 16'($urandom) & 16'($urandom));
        2, 3: regWrite(enA(g, $urandom_range(0, 3)), 16'($urandom));
        4, 5: regWrite(clrA(g), 16'($urandom));
        6, 7: begin
          regRead(statusA(g), d);
          check(d == mPend[g*16 +: 16], "R4 random status", 32'(d), 32'(mPend[g*16 +: 16]));
        end
        default: ;
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule